// File: doc/BRIEF.md
# Dual-Rail Carry Hybrid Adder

This block adds two unsigned operands and a carry-in. The operands, carry-in and sum use bundled data: a single `req` level marks them valid. Inside the block, every carry travels on a pair of rails. A bit position whose operand bits generate or kill a carry settles its carry pair on its own. It does not wait for the carries below it, so the time to finish depends on the data. Each clock edge models one step of carry evaluation. A completion detector watches every carry pair and raises `ack` once all of them hold a valid code.

A transaction is a four-phase handshake. The producer holds the operands steady and raises `req`. It then waits for `ack` and reads `sum` and `cout`. After that it lowers `req`. The block clears every rail pair in one edge, which is a fixed time. It lowers `ack` only once the detector sees every pair empty. The `cycles` port reports how many edges the most recent evaluation took.

Control is a four-state machine. IDLE waits for `req`. EVAL lets the carry pairs resolve. DONE holds the result with `ack` high. DRAIN waits for the rails to read empty.

The transitions are:
- IDLE to EVAL when `req` is high.
- EVAL to DONE when every pair is valid and `req` is still high.
- EVAL to DRAIN when `req` falls early (abort).
- DONE to DRAIN when `req` falls.
- DRAIN to IDLE when every pair reads empty.

Top module: `dr_carry_adder`

## Requirements
- R1: While the machine is in DONE, `{cout,sum}` equals `opa + opb + cin`. In every other state `sum` and `cout` are zero.
- R2: A rail pair encodes carry one as 2'b10, carry zero as 2'b01 and empty as 2'b00. The code 2'b11 never appears.
- R3: A pair's true rail is set by generate, or by propagate with the true rail below it set. Its false rail is set by kill, or by propagate with the false rail below it set. A valid code holds until `req` falls.
- R4: A bit position with generate or kill, and the carry-in pair, resolve on the first edge that samples `req` high. This does not depend on any lower carry. Operands made only of generate and kill bits complete with `cycles` equal to 1.
- R5: `cycles` is the number of edges after the first edge that sees `req` high, up to and including the edge that raises `ack`. It equals the longest run of propagate bits (`opa[i]^opb[i]`) plus one. It reads 0 after reset.
- R6: `ack` rises on the edge after all pairs become valid, that is the longest propagate run plus two edges after `req` is first sampled high. It stays high while `req` stays high.
- R7: The edge that samples `req` low empties every rail pair and zeroes `sum` and `cout`. `ack` falls on the following edge. This two-edge return does not depend on the operands.
- R8: After reset, `ack`, `sum`, `cout` and `cycles` are all zero.
- R9: If `req` falls before `ack` rises, the rails clear and `ack` never rises. The next request then completes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| opa | input | WIDTH | First operand (bundled) |
| opb | input | WIDTH | Second operand (bundled) |
| cin | input | 1 | Carry-in (bundled) |
| req | input | 1 | Four-phase request |
| sum | output | WIDTH | Sum, valid while the result is held |
| cout | output | 1 | Carry-out |
| ack | output | 1 | Four-phase acknowledge |
| cycles | output | $clog2(WIDTH+2) | Edges taken by the last evaluation |

## Verification
Operands made only of generate and kill bits show the shortest latency of one resolution edge. This separates weak indication from a ripple that waits on every carry. Full-length propagate runs, such as `0xFFFF+0` with a carry-in of one and alternating complements, give the worst case of seventeen edges. A single propagate run placed in the middle of the word shows that only the longest run sets the latency, not its position or the carry-in. Early release of `req` during a long run, and release after completion for both short and long patterns, show that the return-to-empty path is abortable and takes the same time for any data.

// File: rtl/dra_pkg.sv
package dra_pkg;

    // Dual-rail carry codes: {true_rail, false_rail}
    localparam logic [1:0] RAIL_EMPTY = 2'b00;
    localparam logic [1:0] RAIL_ONE   = 2'b10;
    localparam logic [1:0] RAIL_ZERO  = 2'b01;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_EVAL,
        ST_DONE,
        ST_DRAIN
    } adder_state_t;

endpackage

// File: rtl/dra_carry_stage.sv
module dra_carry_stage
    import dra_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       clr,
    input  logic       bit_a,
    input  logic       bit_b,
    input  logic [1:0] rail_in,
    output logic [1:0] rail_out
);

    logic gen, kill, prop;
    logic [1:0] rail_q, rail_d;

    assign gen  = bit_a & bit_b;
    assign kill = ~bit_a & ~bit_b;
    assign prop = bit_a ^ bit_b;

    always_comb begin
        rail_d = rail_q;
        if (clr) begin
            rail_d = RAIL_EMPTY;
        end else if (en && rail_q == RAIL_EMPTY) begin
            if (gen)
                rail_d = RAIL_ONE;
            else if (kill)
                rail_d = RAIL_ZERO;
            else if (prop && rail_in != RAIL_EMPTY)
                rail_d = rail_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rail_q <= RAIL_EMPTY;
        else
            rail_q <= rail_d;
    end

    assign rail_out = rail_q;

    AST_NO_ILLEGAL_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        rail_q != 2'b11); // R2

    AST_VALID_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (rail_q != RAIL_EMPTY && !clr) |=> $stable(rail_q)); // R3

    AST_EARLY_RESOLVE: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !clr && (gen || kill)) |=> (rail_q != RAIL_EMPTY)); // R4

endmodule

// File: rtl/dra_completion.sv
module dra_completion
    import dra_pkg::*;
#(
    parameter int PAIRS = 17
) (
    input  logic [PAIRS-1:0][1:0] rails,
    output logic                  all_valid,
    output logic                  all_empty
);

    logic [PAIRS-1:0] pair_valid;
    logic [PAIRS-1:0] pair_empty;

    for (genvar j = 0; j < PAIRS; j++) begin : g_pair
        assign pair_valid[j] = rails[j][1] ^ rails[j][0];
        assign pair_empty[j] = (rails[j] == RAIL_EMPTY);
    end

    assign all_valid = &pair_valid;
    assign all_empty = &pair_empty;

endmodule

// File: rtl/dr_carry_adder.sv
module dr_carry_adder
    import dra_pkg::*;
#(
    parameter int WIDTH = 16,
    localparam int PAIRS = WIDTH + 1,
    localparam int CW    = $clog2(WIDTH + 2)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    input  logic             cin,
    input  logic             req,
    output logic [WIDTH-1:0] sum,
    output logic             cout,
    output logic             ack,
    output logic [CW-1:0]    cycles
);

    adder_state_t state_q, state_d;
    logic [PAIRS-1:0][1:0] rails;   // rails[i] = carry into bit i; rails[WIDTH] = carry-out
    logic all_valid, all_empty;
    logic stage_en, stage_clr;
    logic ack_q;
    logic [CW-1:0] cnt_q;

    assign stage_clr = ~req;
    assign stage_en  = req && (state_q != ST_DRAIN);

    // Carry-in pair: a = b = cin gives generate or kill, never propagate
    dra_carry_stage u_cin_stage (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (stage_en),
        .clr      (stage_clr),
        .bit_a    (cin),
        .bit_b    (cin),
        .rail_in  (RAIL_EMPTY),
        .rail_out (rails[0])
    );

    for (genvar i = 0; i < WIDTH; i++) begin : g_stage
        dra_carry_stage u_stage (
            .clk      (clk),
            .rst_n    (rst_n),
            .en       (stage_en),
            .clr      (stage_clr),
            .bit_a    (opa[i]),
            .bit_b    (opb[i]),
            .rail_in  (rails[i]),
            .rail_out (rails[i+1])
        );
    end

    dra_completion #(.PAIRS(PAIRS)) u_cd (
        .rails     (rails),
        .all_valid (all_valid),
        .all_empty (all_empty)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req) state_d = ST_EVAL;
            ST_EVAL:  if (!req) state_d = ST_DRAIN;
                      else if (all_valid) state_d = ST_DONE;
            ST_DONE:  if (!req) state_d = ST_DRAIN;
            ST_DRAIN: if (all_empty) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_q <= 1'b0;
            cnt_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE:  if (req) cnt_q <= '0;
                ST_EVAL: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (req && all_valid) ack_q <= 1'b1;
                end
                ST_DONE:  ack_q <= 1'b1;
                ST_DRAIN: if (all_empty) ack_q <= 1'b0;
                default:  ack_q <= 1'b0;
            endcase
        end
    end

    logic result_ok;
    assign result_ok = (state_q == ST_DONE);

    for (genvar i = 0; i < WIDTH; i++) begin : g_sum
        assign sum[i] = result_ok & ((opa[i] ^ opb[i]) ^ rails[i][1]);
    end
    assign cout   = result_ok & rails[WIDTH][1];
    assign ack    = ack_q;
    assign cycles = cnt_q;

    AST_SUM_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE) |-> ({cout, sum} == ({1'b0, opa} + {1'b0, opb} + PAIRS'(cin)))); // R1

    AST_ACK_RISE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_q) |-> all_valid); // R6

    AST_ACK_FALL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ack_q) |-> all_empty); // R7

    AST_CLEAR_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE && !req) |=> all_empty); // R7

    AST_CYCLES_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        ack_q |-> (cnt_q <= CW'(WIDTH + 1))); // R5

    AST_ABORT_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EVAL && !req) |=> !ack_q); // R9

endmodule

// File: tb/dr_carry_adder_tb.sv
module dr_carry_adder_tb;

    localparam int WIDTH = 16;
    localparam int CW    = $clog2(WIDTH + 2);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [WIDTH-1:0] opa = '0;
    logic [WIDTH-1:0] opb = '0;
    logic             cin = 1'b0;
    logic             req = 1'b0;
    logic [WIDTH-1:0] sum;
    logic             cout;
    logic             ack;
    logic [CW-1:0]    cycles;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    dr_carry_adder #(.WIDTH(WIDTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .opa(opa), .opb(opb), .cin(cin),
        .req(req), .sum(sum), .cout(cout), .ack(ack), .cycles(cycles)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    function automatic int longest_run(input logic [WIDTH-1:0] a, input logic [WIDTH-1:0] b);
        int best = 0;
        int cur = 0;
        for (int i = 0; i < WIDTH; i++) begin
            if (a[i] ^ b[i]) cur++;
            else cur = 0;
            if (cur > best) best = cur;
        end
        return best;
    endfunction

    task automatic t_reset();
        check("R8 ack after reset", 32'(ack), 0);
        check("R8 sum after reset", 32'(sum), 0);
        check("R8 cout after reset", 32'(cout), 0);
        check("R8 cycles after reset", 32'(cycles), 0);
    endtask

    // One full handshake with result, latency and return-to-zero checks
    task automatic t_add(input logic [WIDTH-1:0] a, input logic [WIDTH-1:0] b, input logic c);
        int edges = 0;
        int run = longest_run(a, b);
        logic [WIDTH:0] ref_sum = {1'b0, a} + {1'b0, b} + (WIDTH+1)'(c);
        @(negedge clk);
        opa = a; opb = b; cin = c; req = 1'b1;
        check("R1 sum zero before ack", 32'(sum), 0);
        while (!ack && edges < WIDTH + 6) begin
            @(posedge clk); @(negedge clk);
            edges++;
        end
        check("R6 R2 edges until ack", 32'(edges), 32'(run + 2));
        check("R5 cycles equals run plus one", 32'(cycles), 32'(run + 1));
        check("R1 R3 sum", 32'(sum), 32'(ref_sum[WIDTH-1:0]));
        check("R1 R3 cout", 32'(cout), 32'(ref_sum[WIDTH]));
        @(posedge clk); @(negedge clk);
        check("R6 ack held while req high", 32'(ack), 1);
        req = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R7 sum zero one edge after req low", 32'(sum), 0);
        check("R7 ack still high until empty seen", 32'(ack), 1);
        @(posedge clk); @(negedge clk);
        check("R7 ack low two edges after req low", 32'(ack), 0);
    endtask

    task automatic t_weak();
        // only generate and kill bits: every pair resolves on the first edge
        @(negedge clk);
        opa = 16'h00FF; opb = 16'h00FF; cin = 1'b1; req = 1'b1;
        @(posedge clk); @(negedge clk);
        @(posedge clk); @(negedge clk);
        check("R4 ack after two edges with no propagate", 32'(ack), 1);
        check("R4 cycles is one", 32'(cycles), 1);
        check("R4 sum", 32'(sum), 32'h01FF);
        req = 1'b0;
        @(posedge clk); @(negedge clk);
        @(posedge clk); @(negedge clk);
    endtask

    task automatic t_abort();
        @(negedge clk);
        opa = 16'hFFFF; opb = 16'h0000; cin = 1'b1; req = 1'b1;
        repeat (4) begin @(posedge clk); @(negedge clk); end
        req = 1'b0;
        begin
            int seen = 0;
            for (int k = 0; k < WIDTH + 4; k++) begin
                @(posedge clk); @(negedge clk);
                if (ack) seen = 1;
            end
            check("R9 no ack after early release", 32'(seen), 0);
            check("R9 sum zero after abort", 32'(sum), 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_add(16'h0000, 16'h0000, 1'b0);
        t_add(16'hFFFF, 16'h0000, 1'b1);
        t_add(16'hAAAA, 16'h5555, 1'b0);
        t_add(16'h1234, 16'h4321, 1'b1);
        t_add(16'h0FF0, 16'h0000, 1'b1);
        t_add(16'hF00F, 16'hF10F, 1'b0);
        t_weak();
        t_abort();
        t_add(16'h8001, 16'h7FFF, 1'b0);
        t_add(16'hFFFF, 16'hFFFF, 1'b1);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #200000;
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule